// File: doc/BRIEF.md
# Resource Layer Mapper

The block holds a small table that records, for every functional-unit instance, which layer window of the register space that instance answers in. Software never sees the table directly. It selects a resource kind through one 32-bit access register and then writes or reads a packed word of 4-bit layer numbers through a second one. Only the layer choice is programmable. Each unit kind sits at a fixed slot inside every 0x200-byte layer window.

On the decode side, an incoming register offset is split into a layer number and a unit-kind slot. The block then raises, one cycle later, either the global-space select or the one-hot select of the instance whose programmed layer matches. If two instances of one kind claim the same layer, the lowest-numbered instance wins and a one-cycle error flag is raised.

Top module: `res_layer_map`

## Requirements
- R1: After reset the selector register reads 0, the assignment word reads 0, every table field is 0 and `sel_global`, `sel_inst` and `dup_err` are low.
- R2: A write with `bus_sel`=0 stores the full 32-bit kind selector, and `bus_rdata` with `bus_sel`=0 returns it unchanged.
- R3: A write with `bus_sel`=1 updates the table entry of the most recently written selector. Nibble f (bits 4f+3:4f) is the layer of instance f. `bus_rdata` with `bus_sel`=1 returns the stored nibbles of the selected kind.
- R4: Kind 0 is the pooled kind and keeps only nibble 0. Kinds 1 to 3 keep nibbles 0 and 1. All other nibbles are ignored on write and read back as 0.
- R5: A selector value of 4 or more is stored and read back. Assignment writes under such a selector leave the table unchanged, and the assignment word then reads 0.
- R6: The layer of an offset is bits [12:9]. A valid offset with layer 0 raises `sel_global` one cycle later, with no instance select.
- R7: For a non-zero layer, the kind is offset bits [8:7]. Select bit kind*2+instance rises one cycle later exactly when that instance's field equals the layer. A field of 0 never matches.
- R8: When several instances of the addressed kind match, only the lowest-numbered one is selected, and `dup_err` is high for that one result cycle.
- R9: When `dec_valid` is low, all decode outputs are low in the following cycle.
- R10: A decode presented in the same cycle as an assignment write resolves against the table as it was before that write. The next decode sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register choice: 0 kind selector, 1 assignment word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register chosen by `bus_sel` |
| dec_valid | input | 1 | Decode request valid |
| dec_offset | input | 13 | Register offset to decode |
| sel_global | output | 1 | Offset falls in the global window (layer 0) |
| sel_inst | output | 8 | One-hot instance select, bit kind*2+instance |
| dup_err | output | 1 | More than one instance claimed the decoded layer |

## Verification
A table update and a decode can land in the same clock cycle, and the order between them is what R10 fixes. The bench provokes this by driving an assignment write and a decode request on the same edge, with the decode aimed at the layer the write is about to move away from. It expects the old owner to be selected on that result cycle, and on the following accesses it expects the new layer to hit and the old layer to miss. Apart from that race, the bench sweeps all 16 layers against all four kinds for several table patterns, and computes every expected select from its own model of the table.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  localparam int REG_W     = 32;
  localparam int FIELD_W   = 4;
  localparam int LAYER_LSB = 9;
  localparam int LAYER_W   = 4;

  // layer window index of a register offset
  function automatic logic [LAYER_W-1:0] layer_of(input logic [REG_W-1:0] ofs);
    return ofs[LAYER_LSB +: LAYER_W];
  endfunction

  // unit-kind slot inside a layer window
  function automatic int kind_of(input logic [REG_W-1:0] ofs, input int kind_w);
    return int'((ofs >> (LAYER_LSB - kind_w)) & ((32'd1 << kind_w) - 32'd1));
  endfunction

  // number of instance fields a kind keeps
  function automatic int fields_for_kind(input int kind, input int pool_kind, input int ninst);
    return (kind == pool_kind) ? 1 : ninst;
  endfunction
endpackage

// File: rtl/rlm_regs.sv
module rlm_regs
  import rlm_pkg::*;
#(
  parameter int NKIND     = 4,
  parameter int NINST     = 2,
  parameter int POOL_KIND = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_sel,
  input  logic [REG_W-1:0]               bus_wdata,
  output logic [REG_W-1:0]               bus_rdata,
  output logic [NKIND*NINST*FIELD_W-1:0] tbl_flat,
  output logic [REG_W-1:0]               asg_word,
  output logic                           id_ok,
  output logic                           wr_id_ev,
  output logic                           wr_asg_ev
);
  logic [REG_W-1:0]               id_q;
  logic [NKIND*NINST*FIELD_W-1:0] tbl_q;

  assign wr_id_ev  = bus_wr && !bus_sel;
  assign wr_asg_ev = bus_wr &&  bus_sel;
  assign id_ok     = id_q < REG_W'(NKIND);
  assign tbl_flat  = tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q  <= '0;
      tbl_q <= '0;
    end else begin
      if (wr_id_ev) id_q <= bus_wdata;
      if (wr_asg_ev && id_ok) begin
        for (int k = 0; k < NKIND; k++) begin
          for (int i = 0; i < NINST; i++) begin
            if (id_q == REG_W'(k) && i < fields_for_kind(k, POOL_KIND, NINST))
              tbl_q[(k*NINST+i)*FIELD_W +: FIELD_W] <= bus_wdata[i*FIELD_W +: FIELD_W];
          end
        end
      end
    end
  end

  always_comb begin
    asg_word = '0;
    for (int k = 0; k < NKIND; k++) begin
      for (int i = 0; i < NINST; i++) begin
        if (id_q == REG_W'(k) && i < fields_for_kind(k, POOL_KIND, NINST))
          asg_word[i*FIELD_W +: FIELD_W] = tbl_q[(k*NINST+i)*FIELD_W +: FIELD_W];
      end
    end
  end

  assign bus_rdata = bus_sel ? asg_word : id_q;
endmodule

// File: rtl/rlm_decode.sv
module rlm_decode
  import rlm_pkg::*;
#(
  parameter int NKIND = 4,
  parameter int NINST = 2,
  parameter int OFS_W = 13,
  localparam int NSEL   = NKIND * NINST,
  localparam int KIND_W = $clog2(NKIND)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [OFS_W-1:0]         dec_offset,
  input  logic [NSEL*FIELD_W-1:0]  tbl_flat,
  output logic [NSEL-1:0]          match_vec,
  output logic [NSEL-1:0]          hit_vec,
  output logic                     multi_hit,
  output logic                     sel_global,
  output logic [NSEL-1:0]          sel_inst,
  output logic                     dup_err
);
  logic [LAYER_W-1:0] layer;
  int                 kind;

  assign layer = layer_of(REG_W'(dec_offset));
  assign kind  = kind_of(REG_W'(dec_offset), KIND_W);

  always_comb begin
    match_vec = '0;
    for (int k = 0; k < NKIND; k++) begin
      for (int i = 0; i < NINST; i++) begin
        match_vec[k*NINST+i] = (k == kind) && (layer != '0) &&
                               (tbl_flat[(k*NINST+i)*FIELD_W +: FIELD_W] == layer);
      end
    end
  end

  // keep only the lowest set bit
  assign hit_vec   = match_vec & (~match_vec + NSEL'(1));
  assign multi_hit = |(match_vec & ~hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_global <= 1'b0;
      sel_inst   <= '0;
      dup_err    <= 1'b0;
    end else begin
      sel_global <= dec_valid && (layer == '0);
      sel_inst   <= dec_valid ? hit_vec : '0;
      dup_err    <= dec_valid && multi_hit;
    end
  end
endmodule

// File: rtl/res_layer_map.sv
module res_layer_map
  import rlm_pkg::*;
#(
  parameter int NKIND     = 4,
  parameter int NINST     = 2,
  parameter int POOL_KIND = 0,
  parameter int OFS_W     = 13,
  localparam int NSEL     = NKIND * NINST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             dec_valid,
  input  logic [OFS_W-1:0] dec_offset,
  output logic             sel_global,
  output logic [NSEL-1:0]  sel_inst,
  output logic             dup_err
);
  logic [NSEL*FIELD_W-1:0] tbl_flat;
  logic [REG_W-1:0]        asg_word;
  logic                    id_ok;
  logic                    wr_id_ev;
  logic                    wr_asg_ev;
  logic [NSEL-1:0]         match_vec;
  logic [NSEL-1:0]         hit_vec;
  logic                    multi_hit;

  rlm_regs #(.NKIND(NKIND), .NINST(NINST), .POOL_KIND(POOL_KIND)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tbl_flat  (tbl_flat),
    .asg_word  (asg_word),
    .id_ok     (id_ok),
    .wr_id_ev  (wr_id_ev),
    .wr_asg_ev (wr_asg_ev)
  );

  rlm_decode #(.NKIND(NKIND), .NINST(NINST), .OFS_W(OFS_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_offset (dec_offset),
    .tbl_flat   (tbl_flat),
    .match_vec  (match_vec),
    .hit_vec    (hit_vec),
    .multi_hit  (multi_hit),
    .sel_global (sel_global),
    .sel_inst   (sel_inst),
    .dup_err    (dup_err)
  );
endmodule

// File: rtl/res_layer_map_chk.sv
module res_layer_map_chk #(
  parameter int NKIND     = 4,
  parameter int NINST     = 2,
  parameter int POOL_KIND = 0,
  localparam int NSEL     = NKIND * NINST
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              sel_global,
  input logic [NSEL-1:0]   sel_inst,
  input logic              dup_err,
  input logic [NSEL*4-1:0] tbl_flat,
  input logic [31:0]       asg_word,
  input logic              id_ok,
  input logic              wr_id_ev,
  input logic              wr_asg_ev
);
  localparam logic [63:0] USED_MASK = (64'd1 << (NINST*4)) - 64'd1;
  localparam int          POOL_SPARE = (POOL_KIND*NINST + 1) * 4;

  a_r7_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_inst));

  a_r6_global_excludes_inst: assert property (@(posedge clk) disable iff (!rst_n)
    sel_global |-> (sel_inst == '0));

  a_r8_dup_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> ($countones(sel_inst) == 1));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (sel_inst == '0 && !sel_global && !dup_err));

  a_r5_bad_id_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_asg_ev && !id_ok) |=> $stable(tbl_flat));

  a_r2_id_write_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
    wr_id_ev |=> $stable(tbl_flat));

  a_r4_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(asg_word) & ~USED_MASK) == 64'd0);

  generate
    if (NINST > 1) begin : g_pool
      a_r4_pool_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_flat[POOL_SPARE +: 4] == 4'd0);
    end
  endgenerate
endmodule

bind res_layer_map res_layer_map_chk #(
  .NKIND(NKIND), .NINST(NINST), .POOL_KIND(POOL_KIND)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_valid  (dec_valid),
  .sel_global (sel_global),
  .sel_inst   (sel_inst),
  .dup_err    (dup_err),
  .tbl_flat   (tbl_flat),
  .asg_word   (asg_word),
  .id_ok      (id_ok),
  .wr_id_ev   (wr_id_ev),
  .wr_asg_ev  (wr_asg_ev)
);

// File: tb/res_layer_map_test.sv
`timescale 1ns/1ps
module res_layer_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dec_valid = 1'b0;
  logic [12:0] dec_offset = '0;
  logic        sel_global;
  logic [7:0]  sel_inst;
  logic        dup_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          mdl [4][2];
  logic [31:0] mdl_id;

  always #5 clk = ~clk;

  res_layer_map uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dec_valid(dec_valid),
    .dec_offset(dec_offset), .sel_global(sel_global), .sel_inst(sel_inst),
    .dup_err(dup_err)
  );

  function automatic int kept(int k);
    return (k == 0) ? 1 : 2;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // bench model of an assignment write
  function automatic void model_asg(logic [31:0] w);
    if (mdl_id < 4)
      for (int i = 0; i < kept(int'(mdl_id)); i++) mdl[mdl_id][i] = int'((w >> (4*i)) & 32'hF);
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    if (mdl_id < 4)
      for (int i = 0; i < kept(int'(mdl_id)); i++) w = w | (32'(mdl[mdl_id][i]) << (4*i));
    return w;
  endfunction

  // {dup, global, sel[7:0]}
  function automatic logic [31:0] model_dec(int L, int k);
    int first = -1;
    int cnt = 0;
    if (L == 0) return 32'h100;
    for (int i = 0; i < 2; i++)
      if (mdl[k][i] == L) begin
        if (first < 0) first = i;
        cnt++;
      end
    if (first < 0) return 32'h0;
    return (32'(cnt > 1) << 9) | (32'd1 << (k*2 + first));
  endfunction

  task automatic bus_write(logic s, logic [31:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (s) model_asg(d); else mdl_id = d;
  endtask

  task automatic bus_read(string req, logic s, logic [31:0] exp);
    bus_sel = s;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic dec_check(string req, int L, int k);
    dec_valid = 1'b1;
    dec_offset = 13'(L*512 + k*128 + (L*7 + k*13) % 128);
    @(negedge clk);
    check(req, {22'd0, dup_err, sel_global, sel_inst}, model_dec(L, k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) for (int i = 0; i < 2; i++) mdl[k][i] = 0;
    mdl_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 outputs", {22'd0, dup_err, sel_global, sel_inst}, 32'h0);
    bus_read("R1 selector", 1'b0, 32'h0);
    bus_read("R1 word", 1'b1, 32'h0);
    for (int L = 1; L < 16; L += 5) dec_check("R1 unprogrammed", L, L % 4);

    // R2 selector write/readback, R5 undefined selectors
    bus_write(1'b0, 32'hDEAD_BEEF);
    bus_read("R2 selector readback", 1'b0, 32'hDEAD_BEEF);
    bus_write(1'b1, 32'h1111_1111);
    bus_read("R5 bad id word", 1'b1, 32'h0);
    bus_write(1'b0, 32'd9);
    bus_read("R5 id 9 readback", 1'b0, 32'd9);
    bus_write(1'b1, 32'h0000_0022);
    bus_read("R5 id 9 word", 1'b1, 32'h0);

    // pattern sweeps: R3, R4, R6, R7, R8
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        int n0 = (p*3 + k*5 + 1) % 16;
        int n1 = (p == 3) ? n0 : (p*7 + k*3 + 2) % 16;
        if (p == 1 && k == 2) n0 = 0;
        bus_write(1'b0, 32'(k));
        bus_write(1'b1, 32'hABCD_EF00 | 32'(n1 << 4) | 32'(n0));
        bus_read("R3 R4 word readback", 1'b1, model_word());
      end
      bus_write(1'b0, 32'd7);
      bus_write(1'b1, 32'h0000_00FF);
      for (int k = 0; k < 4; k++) begin
        bus_write(1'b0, 32'(k));
        bus_read("R5 table unchanged", 1'b1, model_word());
      end
      for (int L = 0; L < 16; L++)
        for (int k = 0; k < 4; k++)
          dec_check((L == 0) ? "R6 global" : "R7 R8 layer sweep", L, k);
    end

    // R4 pooled kind keeps one field
    bus_write(1'b0, 32'd0);
    bus_write(1'b1, 32'h0000_0099);
    bus_read("R4 pooled word", 1'b1, 32'h9);
    dec_check("R4 pooled select", 9, 0);

    // R8 pulse: duplicate then clean result
    bus_write(1'b0, 32'd2);
    bus_write(1'b1, 32'h0000_0077);
    dec_check("R8 lowest wins", 7, 2);
    bus_write(1'b0, 32'd1);
    bus_write(1'b1, 32'h0000_0003);
    dec_check("R8 pulse ends", 7, 1);

    // R10 write and decode in the same cycle
    dec_check("R10 setup", 3, 1);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 32'h0000_0005;
    dec_valid = 1'b1; dec_offset = 13'(3*512 + 1*128 + 4);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 old table", {22'd0, dup_err, sel_global, sel_inst}, 32'h004);
    model_asg(32'h5);
    dec_check("R10 new layer", 5, 1);
    dec_check("R10 old layer gone", 3, 1);

    // R9 idle
    dec_valid = 1'b0;
    @(negedge clk);
    check("R9 idle", {22'd0, dup_err, sel_global, sel_inst}, 32'h0);
    dec_offset = 13'h0;
    @(negedge clk);
    check("R9 idle global offset", {22'd0, dup_err, sel_global, sel_inst}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule